// File: doc/BRIEF.md
# Exception Mode and Status Controller

This block owns the live program status word of a 32-bit RISC core. It also moves the core between its seven operating modes when an exception is raised. Each cycle it looks at the pending abort, undefined-instruction, software-interrupt, normal-interrupt and fast-interrupt requests. When at least one of them can be taken, it does three things in a single clock edge: it copies the live word into a save register that belongs to the mode being entered, it rewrites the mode field, and it sets the interrupt mask bits. It reports which exception vector the core should fetch from.

Two more operations touch the live word. A return copies the active mode's saved word back into the live word. A status write comes from the core's move-to-status instruction. In user mode that write is limited to the condition flags. Instruction decode, the pipeline and memory are outside this block.

Top module: `psr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it rises, the live word is 0x000000D3: supervisor mode, both interrupt masks set, every other bit 0. Every save register reads 0, `vec_sel` is 0 and `exc_taken` is 0.
- R2: The mode field in bits 4:0 uses these codes: user 10000, fast interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011, system 11111. `cur_mode` always equals bits 4:0 of `status`.
- R3: When several takeable requests arrive in the same cycle, only one is taken. The order is abort, then fast interrupt, then interrupt, then undefined instruction, then software interrupt.
- R4: On exception entry, the live word from before the edge is stored in the save register of the mode entered. That value shows on `saved_status` from the next cycle.
- R5: Every exception entry sets bit 7 (IRQ mask). Fast-interrupt entry also sets bit 6 (FIQ mask). Apart from the mode field, all other bits keep their values.
- R6: An interrupt request is ignored while bit 7 is set. A fast-interrupt request is ignored while bit 6 is set.
- R7: In the cycle after an entry, `exc_taken` is 1 for exactly one cycle. At the same time `vec_sel` gives the vector: undefined 1, software interrupt 2, abort 4, interrupt 6, fast interrupt 7. `vec_sel` holds that value until the next entry.
- R8: `ret_req` copies the active mode's save register into the live word in one cycle. In user or system mode it has no effect.
- R9: A status write replaces the whole live word in a privileged mode. In user mode it changes only bits 31:27.
- R10: `saved_status` reads 0 in user and system mode. Each exception mode keeps its own save register, and entering one mode leaves the other modes' copies untouched.
- R11: In a cycle where an exception is taken, `ret_req` and `st_wr_en` are ignored. A return, when it applies, takes precedence over a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset; enters supervisor mode |
| abort_req | input | 1 | Prefetch or data access error |
| undef_req | input | 1 | Unrecognized or inactive-coprocessor instruction |
| swi_req | input | 1 | Software interrupt request |
| irq_req | input | 1 | Normal interrupt line |
| fiq_req | input | 1 | Fast interrupt line |
| ret_req | input | 1 | Exception return: restore the saved word |
| st_wr_en | input | 1 | Status write strobe |
| st_wr_data | input | 32 | Status write value |
| status | output | 32 | Live status word |
| cur_mode | output | 5 | Current mode field |
| saved_status | output | 32 | Save register of the active mode, 0 in user and system |
| vec_sel | output | 3 | Vector index of the last exception taken |
| exc_taken | output | 1 | One-cycle pulse after an exception entry |

## Verification
The hardest state to reach is a chain of nested exceptions in which the copies belonging to different modes must stay apart. The stimulus first clears both masks with a privileged write and takes a normal interrupt. It then raises a fast interrupt from inside the interrupt mode. Two returns follow, and they must unwind exactly through both copies. The priority order is checked by going down to user mode and then firing every request together, dropping the winner each time and returning between rounds.

// File: rtl/psr_mode_ctrl.sv
`timescale 1ns/1ps
module psr_mode_ctrl #(
  parameter int W = 32,
  parameter int NSAVE = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         abort_req,
  input  logic         undef_req,
  input  logic         swi_req,
  input  logic         irq_req,
  input  logic         fiq_req,
  input  logic         ret_req,
  input  logic         st_wr_en,
  input  logic [W-1:0] st_wr_data,
  output logic [W-1:0] status,
  output logic [4:0]   cur_mode,
  output logic [W-1:0] saved_status,
  output logic [2:0]   vec_sel,
  output logic         exc_taken
);
  localparam logic [4:0] M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
                         M_SVC = 5'b10011, M_ABT = 5'b10111, M_UND = 5'b11011,
                         M_SYS = 5'b11111;
  localparam int SW = $clog2(NSAVE + 1);
  localparam logic [SW-1:0] NONE = SW'(NSAVE);
  localparam logic [W-1:0] RST_WORD = W'({3'b110, M_SVC});

  logic [W-1:0]  bank [NSAVE];
  logic          take, fiq_ok, irq_ok;
  logic [4:0]    nmode;
  logic [2:0]    nvec;
  logic [SW-1:0] cur_slot, new_slot;

  function automatic logic [SW-1:0] slot_of(input logic [4:0] m);
    case (m)
      M_FIQ:   return SW'(0);
      M_IRQ:   return SW'(1);
      M_SVC:   return SW'(2);
      M_ABT:   return SW'(3);
      M_UND:   return SW'(4);
      default: return NONE;
    endcase
  endfunction

  assign cur_mode = status[4:0];
  assign fiq_ok   = fiq_req & ~status[6];
  assign irq_ok   = irq_req & ~status[7];
  assign take     = abort_req | fiq_ok | irq_ok | undef_req | swi_req;
  assign cur_slot = slot_of(cur_mode);
  assign new_slot = slot_of(nmode);
  assign saved_status = (cur_slot == NONE) ? '0 : bank[cur_slot];

  always_comb begin
    nmode = M_SVC;
    nvec  = 3'd2;
    if (abort_req)      begin nmode = M_ABT; nvec = 3'd4; end
    else if (fiq_ok)    begin nmode = M_FIQ; nvec = 3'd7; end
    else if (irq_ok)    begin nmode = M_IRQ; nvec = 3'd6; end
    else if (undef_req) begin nmode = M_UND; nvec = 3'd1; end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status    <= RST_WORD;
      vec_sel   <= '0;
      exc_taken <= 1'b0;
    end else begin
      exc_taken <= take;
      if (take) begin
        vec_sel     <= nvec;
        status[4:0] <= nmode;
        status[7]   <= 1'b1;
        if (nmode == M_FIQ) status[6] <= 1'b1;
      end else if (ret_req && cur_slot != NONE) begin
        status <= bank[cur_slot];
      end else if (st_wr_en) begin
        if (cur_mode == M_USR) status[W-1:W-5] <= st_wr_data[W-1:W-5];
        else                   status <= st_wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSAVE; i++) bank[i] <= '0;
    end else if (take) begin
      bank[new_slot] <= status;
    end
  end

  p_abort_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> cur_mode == M_ABT && vec_sel == 3'd4);
  p_save_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> saved_status == $past(status));
  p_irq_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |-> status[7]);
  p_fiq_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_taken && vec_sel == 3'd7) |-> status[6] && cur_mode == M_FIQ);
  p_irq_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && status[7] && !fiq_req && !abort_req && !undef_req && !swi_req) |=> !exc_taken);
  p_ret_noop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !st_wr_en && !take && (cur_mode == M_USR || cur_mode == M_SYS)) |=> $stable(status));
  p_nosave_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == M_USR || cur_mode == M_SYS) |-> saved_status == '0);
endmodule

// File: tb/psr_mode_ctrl_bench.sv
`timescale 1ns/1ps
module psr_mode_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic abort_req = 0, undef_req = 0, swi_req = 0, irq_req = 0, fiq_req = 0;
  logic ret_req = 0, st_wr_en = 0;
  logic [31:0] st_wr_data = 0;
  logic [31:0] status, saved_status;
  logic [4:0] cur_mode;
  logic [2:0] vec_sel;
  logic exc_taken;
  int checks = 0, errors = 0, cycles = 0;

  psr_mode_ctrl u_psr_mode_ctrl (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    {abort_req, undef_req, swi_req, irq_req, fiq_req, ret_req, st_wr_en} = '0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic entry(input string req, input logic [31:0] st, input logic [31:0] sv, input logic [2:0] v);
    chk({req, " status"}, status, st);
    chk({req, " mode"}, {27'b0, cur_mode}, {27'b0, st[4:0]});
    chk({req, " saved"}, saved_status, sv);
    chk({req, " vec"}, {29'b0, vec_sel}, {29'b0, v});
    chk({req, " taken"}, {31'b0, exc_taken}, 32'd1);
  endtask

  task automatic t_reset();
    rst_n = 0; idle(); #3;
    chk("R1 status in reset", status, 32'h0000_00D3);
    @(negedge clk); rst_n = 1; @(negedge clk);
    chk("R1 status", status, 32'h0000_00D3);
    chk("R1 R2 mode svc", {27'b0, cur_mode}, 32'h13);
    chk("R1 saved", saved_status, 0);
    chk("R1 vec", {29'b0, vec_sel}, 0);
    chk("R1 taken", {31'b0, exc_taken}, 0);
  endtask

  task automatic t_nested();
    st_wr_en = 1; st_wr_data = 32'hF000_0013; step();
    chk("R9 privileged write", status, 32'hF000_0013);
    irq_req = 1; step();
    entry("R2 R4 R5 R7 irq", 32'hF000_0092, 32'hF000_0013, 3'd6);
    irq_req = 1; step();
    chk("R7 pulse one cycle / R6 irq masked", {31'b0, exc_taken}, 0);
    chk("R6 irq masked status", status, 32'hF000_0092);
    fiq_req = 1; step();
    entry("R5 R7 fiq", 32'hF000_00D1, 32'hF000_0092, 3'd7);
    fiq_req = 1; step();
    chk("R6 fiq masked", {31'b0, exc_taken}, 0);
    chk("R6 fiq masked status", status, 32'hF000_00D1);
    ret_req = 1; step();
    chk("R8 return to irq", status, 32'hF000_0092);
    chk("R10 irq copy kept", saved_status, 32'hF000_0013);
    ret_req = 1; step();
    chk("R8 return to svc", status, 32'hF000_0013);
    chk("R10 svc copy untouched", saved_status, 0);
  endtask

  task automatic t_user();
    st_wr_en = 1; st_wr_data = 32'h0000_0010; step();
    chk("R9 enter user", status, 32'h0000_0010);
    chk("R10 user saved", saved_status, 0);
    st_wr_en = 1; st_wr_data = 32'hFFFF_FFDF; step();
    chk("R9 user flags only", status, 32'hF800_0010);
    ret_req = 1; step();
    chk("R8 return in user", status, 32'hF800_0010);
  endtask

  task automatic t_priority();
    {abort_req, fiq_req, irq_req, undef_req, swi_req} = '1; step();
    entry("R3 abort first", 32'hF800_0097, 32'hF800_0010, 3'd4);
    ret_req = 1; step();
    {fiq_req, irq_req, undef_req, swi_req} = '1; step();
    entry("R3 fiq second", 32'hF800_00D1, 32'hF800_0010, 3'd7);
    ret_req = 1; step();
    {irq_req, undef_req, swi_req} = '1; step();
    entry("R3 irq third", 32'hF800_0092, 32'hF800_0010, 3'd6);
    ret_req = 1; step();
    {undef_req, swi_req} = '1; step();
    entry("R3 undef fourth", 32'hF800_009B, 32'hF800_0010, 3'd1);
    ret_req = 1; step();
    swi_req = 1; step();
    entry("R3 swi last", 32'hF800_0093, 32'hF800_0010, 3'd2);
  endtask

  task automatic t_conflict();
    swi_req = 1; ret_req = 1; st_wr_en = 1; st_wr_data = 0; step();
    entry("R11 exception beats ret and write", 32'hF800_0093, 32'hF800_0093, 3'd2);
    ret_req = 1; st_wr_en = 1; st_wr_data = 0; step();
    chk("R11 ret beats write", status, 32'hF800_0093);
  endtask

  task automatic t_system();
    st_wr_en = 1; st_wr_data = 32'h0000_001F; step();
    chk("R2 R9 system mode", status, 32'h0000_001F);
    chk("R10 system saved", saved_status, 0);
    ret_req = 1; step();
    chk("R8 return in system", status, 32'h0000_001F);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_nested();
    t_user();
    t_priority();
    t_conflict();
    t_system();
    t_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog actual %0d expected below 20000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end
endmodule